// File: doc/BRIEF.md
# Integer to single-precision float converter with field select

This block turns an integer field of a 32-bit operand into an IEEE-754 single-precision value. A 3-bit mode picks how the operand is read. It can be a whole two's complement word or a whole unsigned word. It can be one of the four bytes taken as an unsigned number. It can also be the low nibble, read as a signed 4-bit code and scaled to a fraction between -0.5 and 0.4375 in sixteenths.

Operands enter on a valid/ready stream and results leave on another one. A single output register sits between them. An operand is accepted on a rising edge when `in_valid` and `in_ready` are both high. Its result is held in the output register with `out_valid` high until a rising edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so the unit sustains one conversion per cycle with no bubble.

Mode encoding (`in_mode`): `000` signed word, `001` unsigned word, `010` signed nibble fraction, `011` reserved, `1kk` unsigned byte k.

Top module: `itof_byte_cvt`

## Requirements
- R1: Mode `000` reads all 32 operand bits as a two's complement integer and returns its single-precision value.
- R2: Mode `001` reads all 32 operand bits as an unsigned integer and returns its single-precision value.
- R3: Mode `1kk` (k = 0..3, in bits [1:0] of the mode) converts the unsigned value of operand bits [8k+7:8k]. The other 24 bits have no effect.
- R4: Mode `010` returns (((x & 0xF) ^ 8) / 16) - 0.5. Code 0x8 gives -0.5 (0xBF000000) and code 0x7 gives 0.4375 (0x3EE00000). Operand bits [31:4] have no effect.
- R5: A value that needs more than 24 significant bits is rounded to nearest, with ties to even. For example, 0x01000001 unsigned gives 0x4B800000, 0x01000003 gives 0x4B800002, and 0x7FFFFFFF signed gives 0x4F000000.
- R6: A zero field in any mode gives +0.0 (0x00000000).
- R7: Operand 0x80000000 in mode `000` gives exactly -2^31 (0xCF000000).
- R8: An operand accepted on one rising edge has its result on `out_data`, with `out_valid` high, immediately after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. An operand offered while `in_ready` is low is not taken.
- R11: Reserved mode `011` gives +0.0.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_mode | input | 3 | Field and interpretation select |
| in_data | input | 32 | Integer operand |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Single-precision result |

## Verification
Any fault in the field selector, the leading-zero count or the rounding stage shows up on `out_data` on the edge right after the operand is accepted. A miscount of leading zeros shows as a wrong exponent. A missed rounding decision shows as a one-ulp error, and only on operands wider than 24 bits. A fault in the output register or the ready logic shows as a lost, duplicated or changed result during a stall. That is visible within the first cycle in which `out_ready` is held low.

// File: rtl/itof_pkg.sv
package itof_pkg;
  localparam int unsigned OPW   = 32;
  localparam int unsigned EXPW  = 8;
  localparam int unsigned MANW  = 23;
  localparam int unsigned BIAS  = 127;
  localparam int unsigned NIBSH = 4;

  typedef enum logic [2:0] {
    MD_SWORD = 3'b000,
    MD_UWORD = 3'b001,
    MD_NIBF  = 3'b010,
    MD_RSVD  = 3'b011,
    MD_BYTE0 = 3'b100,
    MD_BYTE1 = 3'b101,
    MD_BYTE2 = 3'b110,
    MD_BYTE3 = 3'b111
  } cvt_mode_e;
endpackage

// File: rtl/itof_operand_sel.sv
module itof_operand_sel #(
  parameter int unsigned W     = 32,
  parameter int unsigned LANEW = 8,
  parameter int unsigned NIBW  = 4,
  parameter int unsigned SHW   = 3
) (
  input  logic [2:0]     mode,
  input  logic [W-1:0]   opnd,
  output logic           neg,
  output logic [W-1:0]   mag,
  output logic [SHW-1:0] scale_dn
);
  localparam int unsigned LANES = W / LANEW;

  logic [LANES-1:0][W-1:0] lane_val;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_val[g] = {{(W-LANEW){1'b0}}, opnd[g*LANEW +: LANEW]};
    end
  endgenerate

  logic [NIBW-1:0] nib;
  assign nib = opnd[NIBW-1:0];

  always_comb begin
    neg      = 1'b0;
    mag      = '0;
    scale_dn = '0;
    if (mode[2]) begin
      mag = lane_val[mode[1:0]];
    end else begin
      unique case (mode[1:0])
        2'b00: begin
          neg = opnd[W-1];
          mag = opnd[W-1] ? (~opnd + 1'b1) : opnd;
        end
        2'b01: mag = opnd;
        2'b10: begin
          neg      = nib[NIBW-1];
          mag      = {{(W-NIBW){1'b0}}, (nib[NIBW-1] ? (~nib + 1'b1) : nib)};
          scale_dn = SHW'(NIBW);
        end
        default: mag = '0;
      endcase
    end
  end
endmodule

// File: rtl/itof_lzc.sv
module itof_lzc #(
  parameter int unsigned W   = 32,
  parameter int unsigned CW  = $clog2(W)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] zeros,
  output logic          all_zero
);
  always_comb begin
    logic hit;
    hit   = 1'b0;
    zeros = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && val[i]) begin
        zeros = CW'(W - 1 - i);
        hit   = 1'b1;
      end
    end
    all_zero = ~hit;
  end
endmodule

// File: rtl/itof_norm_round.sv
module itof_norm_round #(
  parameter int unsigned W    = 32,
  parameter int unsigned EW   = 8,
  parameter int unsigned MW   = 23,
  parameter int unsigned BS   = 127,
  parameter int unsigned CW   = $clog2(W),
  parameter int unsigned SHW  = 3
) (
  input  logic           neg,
  input  logic [W-1:0]   mag,
  input  logic [CW-1:0]  zeros,
  input  logic           all_zero,
  input  logic [SHW-1:0] scale_dn,
  output logic [EW+MW:0] fp
);
  localparam int unsigned GPOS = W - 2 - MW;
  localparam int unsigned XW   = EW + 2;

  logic [W-1:0]  norm;
  logic [MW-1:0] keep;
  logic          guard;
  logic          sticky;
  logic          up;
  logic [MW:0]   sum;
  logic [XW-1:0] exp_raw;
  logic [XW-1:0] exp_fin;

  assign norm    = mag << zeros;
  assign keep    = norm[W-2 -: MW];
  assign guard   = norm[GPOS];
  assign sticky  = |norm[GPOS-1:0];
  assign up      = guard & (sticky | keep[0]);
  assign sum     = {1'b0, keep} + {{MW{1'b0}}, up};
  assign exp_raw = XW'(BS + W - 1) - XW'(zeros) - XW'(scale_dn);
  assign exp_fin = exp_raw + {{(XW-1){1'b0}}, sum[MW]};

  always_comb begin
    if (all_zero) fp = '0;
    else          fp = {neg, exp_fin[EW-1:0], sum[MW-1:0]};
  end
endmodule

// File: rtl/itof_byte_cvt.sv
module itof_byte_cvt
  import itof_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_mode,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data
);
  localparam int unsigned CW  = $clog2(OPW);
  localparam int unsigned SHW = 3;

  logic           s_neg;
  logic [OPW-1:0] s_mag;
  logic [SHW-1:0] s_scale;
  logic [CW-1:0]  s_zeros;
  logic           s_zero;
  logic [OPW-1:0] s_fp;
  logic           take;

  itof_operand_sel #(.W(OPW), .LANEW(8), .NIBW(NIBSH), .SHW(SHW)) u_sel (
    .mode(in_mode), .opnd(in_data), .neg(s_neg), .mag(s_mag), .scale_dn(s_scale)
  );

  itof_lzc #(.W(OPW), .CW(CW)) u_lzc (
    .val(s_mag), .zeros(s_zeros), .all_zero(s_zero)
  );

  itof_norm_round #(.W(OPW), .EW(EXPW), .MW(MANW), .BS(BIAS), .CW(CW), .SHW(SHW)) u_nr (
    .neg(s_neg), .mag(s_mag), .zeros(s_zeros), .all_zero(s_zero),
    .scale_dn(s_scale), .fp(s_fp)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= s_fp;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/itof_byte_cvt_chk.sv
module itof_byte_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  in_mode,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  p_accept_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ready_rule_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_zero_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data == 32'd0) |=> (out_data == 32'd0));

  p_nibble_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 3'b010) |=> (out_data[30:23] <= 8'd126));

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 3'b011) |=> (out_data == 32'd0));
endmodule

bind itof_byte_cvt itof_byte_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/itof_byte_cvt_tb.sv
`timescale 1ns/1ps
module itof_byte_cvt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = 3'b000;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  itof_byte_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] to_single(real r);
    logic [63:0] b;
    logic [22:0] keep;
    logic        g, st;
    logic [23:0] s;
    int          e;
    if (r == 0.0) return 32'h0;
    b    = $realtobits(r);
    keep = b[51:29];
    g    = b[28];
    st   = |b[27:0];
    s    = {1'b0, keep} + ((g && (st || keep[0])) ? 24'd1 : 24'd0);
    e    = int'(b[62:52]) - 1023 + 127 + (s[23] ? 1 : 0);
    return {b[63], e[7:0], s[22:0]};
  endfunction

  function automatic logic [31:0] model(logic [2:0] md, logic [31:0] x);
    real r;
    case (md)
      3'b000: r = real'($signed(x));
      3'b001: r = real'(x);
      3'b010: r = real'(int'(({28'd0, x[3:0]} ^ 32'd8))) / 16.0 - 0.5;
      3'b011: r = 0.0;
      default: r = real'(int'((x >> (8 * int'(md[1:0]))) & 32'hFF));
    endcase
    return to_single(r);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [2:0] md, logic [31:0] x);
    @(negedge clk);
    in_mode  = md;
    in_data  = x;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, model(md, x));
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R12 out_valid", {31'd0, out_valid}, 32'd0);
    check("R12 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // R7 and R1/R2 corners, R5 rounding, R6 zero
    apply("R7", 3'b000, 32'h80000000);
    check("R7 literal", out_data, 32'hCF000000);
    apply("R5 tie-even down", 3'b001, 32'h01000001);
    check("R5 literal a", out_data, 32'h4B800000);
    apply("R5 tie-even up", 3'b001, 32'h01000003);
    check("R5 literal b", out_data, 32'h4B800002);
    apply("R5 carry", 3'b000, 32'h7FFFFFFF);
    check("R5 literal c", out_data, 32'h4F000000);
    apply("R5 uword max", 3'b001, 32'hFFFFFFFF);
    apply("R1 minus one", 3'b000, 32'hFFFFFFFF);
    apply("R1 one", 3'b000, 32'h00000001);
    apply("R6 sword zero", 3'b000, 32'h0);
    check("R6 literal", out_data, 32'h0);
    apply("R6 uword zero", 3'b001, 32'h0);
    apply("R11 reserved", 3'b011, 32'h12345678);
    check("R11 literal", out_data, 32'h0);

    // R4 every nibble code, with junk above
    for (int c = 0; c < 16; c++) begin
      apply("R4", 3'b010, {28'hABCDEF1, 4'(c)});
      apply("R4 upper ignored", 3'b010, {28'h0, 4'(c)});
    end
    apply("R4 low end", 3'b010, 32'h8);
    check("R4 literal -0.5", out_data, 32'hBF000000);
    apply("R4 high end", 3'b010, 32'h7);
    check("R4 literal 0.4375", out_data, 32'h3EE00000);

    // R3 every value in every lane, other bytes random
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] x;
        x = $urandom();
        x[8*k +: 8] = 8'(v);
        apply("R3", {1'b1, 2'(k)}, x);
      end
    end

    // R1/R2 random widths
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] x;
      x = $urandom() >> ($urandom() % 32);
      apply("R1", 3'b000, x);
      apply("R2", 3'b001, x);
    end

    // R9/R10 stall
    @(negedge clk);
    out_ready = 1'b0;
    in_mode   = 3'b001;
    in_data   = 32'd1000;
    in_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    held     = out_data;
    in_data  = 32'd77;
    check("R10 ready low", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R9 valid held", {31'd0, out_valid}, 32'd1);
    check("R9 data held", out_data, model(3'b001, 32'd1000));
    check("R10 not taken", out_data, held);
    check("R10 ready still low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    #0.1;
    check("R10 ready on drain", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 taken on drain", out_data, model(3'b001, 32'd77));
    @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule